// File: doc/BRIEF.md
# Single-Wire Half-Duplex UART Transceiver

This block is an asynchronous serial transceiver that can run with either two separate data wires or one shared wire. In full-duplex operation the transmitter drives its pad all the time and the receiver listens on a dedicated receive input. In single-wire operation the transmit pad is the only data line. The transmitter enables the pad driver only while a frame is on the wire. The receiver listens on that same pad and ignores the dedicated receive input.

The host writes a data word through a valid/ready pair and collects received words from a one-cycle valid pulse, which also carries a framing-error flag. A baud divisor sets how many clock cycles make one oversampling tick. One bit lasts sixteen ticks. When the pad is released, an external pull-up must hold it high, so the pad acts as an open-drain or floating-input pin. The block does not arbitrate when two talkers collide on the shared wire; higher-level control must prevent that. Synchronous clock output and the other special line modes do not exist in this block, so nothing needs to be switched off before single-wire use.

Top module: `swuart_top`

## Requirements
- R1: During and right after reset, `tx_ready` is 1, `rx_valid` is 0, `line_out` is 1, and `line_oe` is 0 while `hd_en` is 1.
- R2: A transmitted frame is one low start bit, then DATA_W data bits least significant bit first, then one high stop bit. Each bit lasts exactly 16*`baud_div` clock cycles, and a divisor of 0 acts as 1. The start bit appears on `line_out` in the cycle after the accepting edge.
- R3: With `hd_en`=1, `line_oe` is 1 from the cycle after acceptance until the last cycle of the stop bit. It is 0 from the next cycle on, and it stays 0 while idle or receiving.
- R4: With `hd_en`=0, `line_oe` is 1 at all times, including after a frame ends.
- R5: With `hd_en`=1, the receiver takes its data from `line_in`, and a frame on `rx_pin` produces no `rx_valid`.
- R6: With `hd_en`=0, the receiver takes its data from `rx_pin`, and a frame on the shared pad produces no `rx_valid`.
- R7: With `hd_en`=1, the block's own transmitted frame is not received back, so no `rx_valid` follows it.
- R8: A start is a falling edge on the selected input that is still low half a bit time later. A low pulse shorter than that is dropped, and the receiver still accepts the next real frame.
- R9: Each received word gives exactly one single-cycle `rx_valid` pulse with `rx_data` holding the bits sampled at mid-bit, least significant bit first.
- R10: If the stop bit is sampled low, `rx_frame_err` is 1 together with the `rx_valid` pulse, and the data bits are still delivered.
- R11: `tx_ready` goes to 0 in the cycle after a word is accepted and returns to 1 when the stop bit ends. A `tx_valid` that arrives while `tx_ready` is 0 is ignored and does not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_en | input | 1 | 1 selects single-wire operation, 0 selects separate receive input |
| baud_div | input | DIV_W | Clock cycles per oversampling tick (0 treated as 1) |
| tx_data | input | DATA_W | Word to transmit |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle; a request is accepted when valid and ready are both 1 |
| rx_pin | input | 1 | Dedicated receive input, used only when `hd_en`=0 |
| line_in | input | 1 | Level read back from the shared pad |
| line_out | output | 1 | Level driven onto the shared pad |
| line_oe | output | 1 | Pad driver enable |
| rx_data | output | DATA_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse when a word is received |
| rx_frame_err | output | 1 | Stop bit was sampled low, valid with `rx_valid` |

## Verification
The assertions assume that `hd_en` and `baud_div` stay constant while a frame is being sent or received, and that the pad reads high whenever no driver pulls it low. The bench changes mode and divisor only between frames, after the receiver has gone idle. It models the pad as a wired-AND of the block's driver, an external talker and a pull-up. The external talker never drives while the block is transmitting, because the block has no collision handling.

// File: rtl/swuart_pkg.sv
package swuart_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } frame_st_t;
endpackage

// File: rtl/swuart_baud.sv
module swuart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (div == '0) ? DIV_W'(1) : div;
        tick = !clr && (cnt_q == lim - DIV_W'(1));
        if (clr || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/swuart_tx.sv
module swuart_tx
    import swuart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              accept,
    output logic              txd,
    output logic              active
);
    localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        frame_st_t         st;
        logic [SUB_W-1:0]  sub;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shreg;
        logic              txd;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        accept = 1'b0;
        if (s_q.st == FR_IDLE) begin
            if (valid) begin
                accept     = 1'b1;
                s_d.st     = FR_START;
                s_d.txd    = 1'b0;
                s_d.shreg  = data;
                s_d.sub    = '0;
                s_d.bitn   = '0;
            end
        end else if (tick) begin
            if (s_q.sub == SUB_W'(OSR - 1)) begin
                s_d.sub = '0;
                unique case (s_q.st)
                    FR_START: begin
                        s_d.st  = FR_DATA;
                        s_d.txd = s_q.shreg[0];
                    end
                    FR_DATA: begin
                        if (s_q.bitn == BIT_W'(DATA_W - 1)) begin
                            s_d.st  = FR_STOP;
                            s_d.txd = 1'b1;
                        end else begin
                            s_d.bitn  = s_q.bitn + BIT_W'(1);
                            s_d.shreg = s_q.shreg >> 1;
                            s_d.txd   = s_q.shreg[1];
                        end
                    end
                    default: begin
                        s_d.st  = FR_IDLE;
                        s_d.txd = 1'b1;
                    end
                endcase
            end else begin
                s_d.sub = s_q.sub + SUB_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: FR_IDLE, sub: '0, bitn: '0, shreg: '0, txd: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready  = (s_q.st == FR_IDLE);
    assign active = (s_q.st != FR_IDLE);
    assign txd    = s_q.txd;

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !ready);
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !txd);
    p_stop_high_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(txd));
    p_bits_move_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(tick)) |-> $stable(txd));
endmodule

// File: rtl/swuart_rx.sv
module swuart_rx
    import swuart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              din,
    output logic              clr,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              ferr
);
    localparam int SUB_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int HALF  = OSR / 2;

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              s3;
        frame_st_t         st;
        logic [SUB_W-1:0]  sub;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] word;
        logic              valid;
        logic              ferr;
    } rx_state_t;

    rx_state_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.s1    = din;
        r_d.s2    = r_q.s1;
        r_d.s3    = r_q.s2;
        r_d.valid = 1'b0;
        r_d.ferr  = 1'b0;
        clr       = 1'b0;
        unique case (r_q.st)
            FR_IDLE: begin
                if (r_q.s3 && !r_q.s2) begin
                    clr     = 1'b1;
                    r_d.st  = FR_START;
                    r_d.sub = '0;
                end
            end
            FR_START: begin
                if (tick) begin
                    if (r_q.sub == SUB_W'(HALF - 1)) begin
                        r_d.sub  = '0;
                        r_d.bitn = '0;
                        r_d.st   = r_q.s2 ? FR_IDLE : FR_DATA;
                    end else begin
                        r_d.sub = r_q.sub + SUB_W'(1);
                    end
                end
            end
            FR_DATA: begin
                if (tick) begin
                    if (r_q.sub == SUB_W'(OSR - 1)) begin
                        r_d.sub   = '0;
                        r_d.shreg = {r_q.s2, r_q.shreg[DATA_W-1:1]};
                        if (r_q.bitn == BIT_W'(DATA_W - 1)) begin
                            r_d.st = FR_STOP;
                        end else begin
                            r_d.bitn = r_q.bitn + BIT_W'(1);
                        end
                    end else begin
                        r_d.sub = r_q.sub + SUB_W'(1);
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (r_q.sub == SUB_W'(OSR - 1)) begin
                        r_d.sub   = '0;
                        r_d.st    = FR_IDLE;
                        r_d.valid = 1'b1;
                        r_d.word  = r_q.shreg;
                        r_d.ferr  = !r_q.s2;
                    end else begin
                        r_d.sub = r_q.sub + SUB_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1, st: FR_IDLE, sub: '0,
                     bitn: '0, shreg: '0, word: '0, valid: 1'b0, ferr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign data  = r_q.word;
    assign valid = r_q.valid;
    assign ferr  = r_q.ferr;

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    p_err_with_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ferr |-> valid);
    p_start_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == FR_IDLE && !clr) |=> (r_q.st == FR_IDLE));
endmodule

// File: rtl/swuart_top.sv
module swuart_top #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_en,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              rx_pin,
    input  logic              line_in,
    output logic              line_out,
    output logic              line_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err
);
    logic tx_tick, rx_tick;
    logic tx_accept, tx_active, rx_clr;
    logic rx_src;

    swuart_baud #(.DIV_W(DIV_W)) u_tx_baud (
        .clk(clk), .rst_n(rst_n), .clr(tx_accept), .div(baud_div), .tick(tx_tick)
    );

    swuart_baud #(.DIV_W(DIV_W)) u_rx_baud (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .div(baud_div), .tick(rx_tick)
    );

    swuart_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick), .data(tx_data), .valid(tx_valid),
        .ready(tx_ready), .accept(tx_accept), .txd(line_out), .active(tx_active)
    );

    // Single-wire: listen on the pad, but blank it while our own frame is out.
    always_comb begin
        if (hd_en) begin
            rx_src = tx_active ? 1'b1 : line_in;
        end else begin
            rx_src = rx_pin;
        end
        line_oe = hd_en ? tx_active : 1'b1;
    end

    swuart_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .din(rx_src), .clr(rx_clr),
        .data(rx_data), .valid(rx_valid), .ferr(rx_frame_err)
    );

    p_release_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_en && tx_ready) |-> !line_oe);
    p_driver_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> line_oe);
endmodule

// File: tb/tb_swuart_top.sv
`timescale 1ns/1ps
module tb_swuart_top;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hd_en = 1'b1;
    logic [DIV_W-1:0] baud_div = 16'd2;
    logic [DATA_W-1:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready;
    logic rx_pin = 1'b1;
    logic line_in, line_out, line_oe;
    logic [DATA_W-1:0] rx_data;
    logic rx_valid, rx_frame_err;
    logic ext_oe = 1'b0;
    logic ext_val = 1'b1;

    int errors = 0;
    int checks = 0;
    int rx_cnt = 0;
    logic [DATA_W-1:0] last_data = '0;
    logic last_err = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // wired-AND pad with pull-up
    assign line_in = (line_oe ? line_out : 1'b1) & (ext_oe ? ext_val : 1'b1);

    swuart_top #(.DATA_W(DATA_W), .DIV_W(DIV_W), .OSR(16)) dut (
        .clk(clk), .rst_n(rst_n), .hd_en(hd_en), .baud_div(baud_div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_pin(rx_pin), .line_in(line_in), .line_out(line_out), .line_oe(line_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt    <= rx_cnt + 1;
            last_data <= rx_data;
            last_err  <= rx_frame_err;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input bit on_pad, input bit v, input int cyc);
        if (on_pad) begin
            ext_oe  = !v;
            ext_val = v;
        end else begin
            rx_pin = v;
        end
        repeat (cyc) @(posedge clk);
    endtask

    task automatic send_ext(input bit on_pad, input logic [7:0] d, input bit stopv, input int dv);
        int b;
        b = 16 * ((dv == 0) ? 1 : dv);
        @(posedge clk);
        #1;
        drive_bit(on_pad, 1'b0, b);
        for (int i = 0; i < DATA_W; i++) begin
            #1;
            drive_bit(on_pad, d[i], b);
        end
        #1;
        drive_bit(on_pad, stopv, b);
        #1;
        ext_oe = 1'b0; ext_val = 1'b1; rx_pin = 1'b1;
        repeat (b + 8) @(posedge clk);
    endtask

    // {hd, stop, div[5:0], data[7:0]}
    localparam logic [15:0] VEC [6] = '{
        {1'b1, 1'b1, 6'd2, 8'hA5},
        {1'b1, 1'b1, 6'd1, 8'h00},
        {1'b0, 1'b1, 6'd3, 8'hFF},
        {1'b0, 1'b1, 6'd2, 8'h3C},
        {1'b1, 1'b1, 6'd0, 8'h81},
        {1'b1, 1'b0, 6'd2, 8'h5A}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        int e;
        int b;
        logic [9:0] frame;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tx_ready == 1'b1, "R1 tx_ready in reset", tx_ready, 1);
        check(line_oe == 1'b0 && line_out == 1'b1, "R1 pad released in reset", {line_oe, line_out}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rx_valid == 1'b0 && tx_ready == 1'b1, "R1 after reset", {rx_valid, tx_ready}, 1);

        // table of received frames (R5 R6 R9 R10)
        for (int v = 0; v < 6; v++) begin
            hd_en    = VEC[v][15];
            baud_div = DIV_W'(VEC[v][13:8]);
            base     = rx_cnt;
            send_ext(VEC[v][15], VEC[v][7:0], VEC[v][14], int'(VEC[v][13:8]));
            @(negedge clk);
            check(rx_cnt == base + 1, "R9 one word per frame", rx_cnt - base, 1);
            check(last_data == VEC[v][7:0], VEC[v][15] ? "R5 data from pad" : "R6 data from rx_pin",
                  last_data, VEC[v][7:0]);
            check(last_err == !VEC[v][14], "R10 framing flag", last_err, !VEC[v][14]);
        end

        // R2 R3 R11 R7: transmit waveform in single-wire mode
        hd_en = 1'b1; baud_div = 16'd2; b = 32;
        frame = {1'b1, 8'hC6, 1'b0};
        base = rx_cnt;
        @(negedge clk);
        tx_data = 8'hC6; tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        e = 0;
        for (int k = 0; k < 10; k++) begin
            repeat (k * b + b / 2 - e) @(posedge clk);
            e = k * b + b / 2;
            @(negedge clk);
            check(line_out == frame[k] && line_oe == 1'b1, "R2 R3 bit level while driving",
                  {line_oe, line_out}, {1'b1, frame[k]});
            if (k == 2) begin
                check(tx_ready == 1'b0, "R11 busy mid-frame", tx_ready, 0);
                tx_data = 8'h00; tx_valid = 1'b1;
                @(posedge clk);
                e++;
                #1 tx_valid = 1'b0;
            end
        end
        repeat (10 * b - 1 - e) @(posedge clk);
        @(negedge clk);
        check(line_oe == 1'b1, "R3 driver on in last stop cycle", line_oe, 1);
        @(posedge clk);
        @(negedge clk);
        check(line_oe == 1'b0 && tx_ready == 1'b1, "R3 R11 released at frame end", {line_oe, tx_ready}, 2'b01);
        repeat (100) @(posedge clk);
        @(negedge clk);
        check(rx_cnt == base, "R7 no echo of own frame", rx_cnt - base, 0);
        check(tx_ready == 1'b1 && line_oe == 1'b0, "R11 ignored request sent nothing", {tx_ready, line_oe}, 2'b10);

        // R2: divisor 0 acts as 1 -> 160-cycle frame
        baud_div = 16'd0;
        @(negedge clk);
        tx_data = 8'h55; tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        repeat (159) @(posedge clk);
        @(negedge clk);
        check(tx_ready == 1'b0, "R2 div0 frame still running", tx_ready, 0);
        @(posedge clk);
        @(negedge clk);
        check(tx_ready == 1'b1, "R2 div0 frame length", tx_ready, 1);

        // R4: full duplex keeps driver on
        hd_en = 1'b0; baud_div = 16'd1;
        @(negedge clk);
        check(line_oe == 1'b1, "R4 driver on while idle", line_oe, 1);
        tx_data = 8'h0F; tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        repeat (170) @(posedge clk);
        @(negedge clk);
        check(line_oe == 1'b1 && tx_ready == 1'b1, "R4 driver on after frame", {line_oe, tx_ready}, 2'b11);

        // R5: single-wire ignores rx_pin
        hd_en = 1'b1; baud_div = 16'd2;
        base = rx_cnt;
        send_ext(1'b0, 8'h00, 1'b1, 2);
        @(negedge clk);
        check(rx_cnt == base, "R5 rx_pin ignored", rx_cnt - base, 0);

        // R6: full duplex ignores the pad
        hd_en = 1'b0;
        send_ext(1'b1, 8'h00, 1'b1, 2);
        @(negedge clk);
        check(rx_cnt == base, "R6 pad ignored", rx_cnt - base, 0);

        // R8: short low glitch dropped, next real frame accepted
        hd_en = 1'b1; baud_div = 16'd4;
        @(posedge clk);
        #1 ext_oe = 1'b1; ext_val = 1'b0;
        repeat (5) @(posedge clk);
        #1 ext_oe = 1'b0; ext_val = 1'b1;
        repeat (800) @(posedge clk);
        @(negedge clk);
        check(rx_cnt == base, "R8 glitch rejected", rx_cnt - base, 0);
        send_ext(1'b1, 8'h96, 1'b1, 4);
        @(negedge clk);
        check(rx_cnt == base + 1 && last_data == 8'h96, "R8 frame after glitch", last_data, 8'h96);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule